// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block keeps one processor's small direct-mapped cache coherent with its peers on a shared, atomic snooping bus. Each line is Invalid, Shared or Exclusive (modified). It takes read and write requests from the CPU side and answers hits locally. For a miss it first asks an external arbiter for the bus. Only after the grant does it place the miss transaction on the bus and commit the new line state.

At the same time it watches every transaction that other caches put on the bus. A matching write miss removes the local copy. A matching read miss downgrades an Exclusive copy to Shared, and the controller drives the data-supply strobe. Other caches can issue a miss to the block this controller is waiting on. When that happens during arbitration, the snoop is applied first and the local request is looked up again from scratch. Line data storage is outside this block; the controller handles tags, states and bus commands only.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: A bus command (`bus_cmd_valid`) appears only in a cycle where `bus_gnt` is high. A line's state never changes because of a CPU miss before the grant. While no grant is given, no bus command is issued.
- R2: A miss raises `bus_req` two cycles after the request pulse. The bus command appears in the cycle after the grant is sampled. `cpu_done` pulses for one cycle in the cycle after the last bus command.
- R3: Another cache may issue a snooped read or write miss (`snp_op` 1 or 2) to the exact address being requested. If that snoop arrives while the controller waits for the grant, the controller applies the snoop and drops `bus_req` in the following cycle. It then repeats the lookup and arbitration for its request.
- R4: A read to an Invalid or non-matching line issues a read miss (`bus_cmd_op` = 1) with the requested address, and the line becomes Shared.
- R5: A write to an Invalid or Shared line issues a write miss (`bus_cmd_op` = 2), and the line becomes Exclusive.
- R6: A snooped write miss whose address matches a valid line makes that line Invalid. A snoop whose tag differs from the stored tag changes nothing. A snooped write-back (`snp_op` = 3) also changes nothing.
- R7: A snooped read miss that matches an Exclusive line makes it Shared, and `snp_flush` is high in the next cycle. A snooped write miss matching an Exclusive line also raises `snp_flush`. A match on a Shared line never raises `snp_flush`.
- R8: A read hit on a Shared or Exclusive line, and a write hit on an Exclusive line, need no bus. `cpu_done` pulses two cycles after the request pulse.
- R9: A miss whose index holds an Exclusive line with a different tag first issues a write-back (`bus_cmd_op` = 3) carrying the victim's address. The miss command follows in the next cycle.
- R10: After reset every line is Invalid. `cpu_ready` is high, and `bus_req`, `bus_cmd_valid`, `cpu_done` and `snp_flush` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request pulse, accepted while `cpu_ready` is high |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the request |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_cmd_valid | output | 1 | A command is being driven on the bus |
| bus_cmd_op | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_cmd_addr | output | ADDR_W | Block address of the command |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 2 | Its command code, encoded as for `bus_cmd_op` |
| snp_addr | input | ADDR_W | Its block address |
| snp_flush | output | 1 | This cache supplies and writes back its modified copy |

## Verification
Every result has a fixed latency counted from the cycle in which the stimulus is driven.

| Result | Due in cycle |
|---|---|
| Hit completion | c+2 |
| Miss command (immediate grant) | c+3 |
| Miss completion | c+4 |
| Write-back, then miss, then completion | c+3, c+4, c+5 |
| Flush after a snoop driven in cycle s | s+1 |

The driver stamps each expected bus command, completion and flush with its due cycle and queues it. The monitor, sampling at the falling edge, removes an item only when the design produces that output. It compares opcode, address and cycle, so an early, late, missing or extra output is reported.

Line state is observed at the ports. The bench watches which command a later access produces, or whether that access completes without using the bus.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_NONE   = 2'd0,
        BOP_RDMISS = 2'd1,
        BOP_WRMISS = 2'd2,
        BOP_WBACK  = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic     upd;
        line_st_e nst;
        logic     flush;
    } snp_act_t;

    // Reaction of a valid, tag-matching line to another cache's transaction.
    function automatic snp_act_t snoop_action(bus_op_e op, line_st_e cur);
        snp_act_t a;
        a.upd   = 1'b0;
        a.nst   = cur;
        a.flush = 1'b0;
        case (op)
            BOP_RDMISS: if (cur == ST_EXC) begin
                a.upd   = 1'b1;
                a.nst   = ST_SHR;
                a.flush = 1'b1;
            end
            BOP_WRMISS: begin
                a.upd   = 1'b1;
                a.nst   = ST_INV;
                a.flush = (cur == ST_EXC);
            end
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
    import msi_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_gnt,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [TAG_W-1:0] tag_a,
    output line_st_e         st_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [TAG_W-1:0] tag_b,
    output line_st_e         st_b,
    input  logic             commit_en,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic [TAG_W-1:0] commit_tag,
    input  line_st_e         commit_st,
    input  logic             snp_en,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_e         snp_st
);

    logic [TAG_W-1:0] tag_q [SETS];
    line_st_e         st_q  [SETS];

    for (genvar i = 0; i < SETS; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_INV;
            end else if (commit_en && commit_idx == IDX_W'(i)) begin
                tag_q[i] <= commit_tag;
                st_q[i]  <= commit_st;
            end else if (snp_en && snp_idx == IDX_W'(i)) begin
                st_q[i]  <= snp_st;
            end
        end
    end

    assign tag_a = tag_q[rd_idx_a];
    assign st_a  = st_q[rd_idx_a];
    assign tag_b = tag_q[rd_idx_b];
    assign st_b  = st_q[rd_idx_b];

    // A CPU miss may only update the array while the bus is granted.
    assert_commit_granted_R1: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> bus_gnt);

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  bus_op_e           snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_st_e          line_st,
    output logic [IDX_W-1:0]  look_idx,
    output logic              upd_en,
    output line_st_e          upd_st,
    output logic              flush
);

    logic     match;
    snp_act_t act;
    logic     flush_q;

    assign look_idx = snp_addr[IDX_W-1:0];
    assign match    = snp_valid && (line_st != ST_INV) &&
                      (line_tag == snp_addr[ADDR_W-1:IDX_W]);
    assign act      = snoop_action(snp_op, line_st);
    assign upd_en   = match && act.upd;
    assign upd_st   = act.nst;

    always_ff @(posedge clk) begin
        if (rst) flush_q <= 1'b0;
        else     flush_q <= match && act.flush;
    end

    assign flush = flush_q;

    // A supply strobe always follows an observed bus transaction.
    assert_flush_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> $past(snp_valid));

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [IDX_W-1:0]  req_idx,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_st_e          line_st,
    input  logic              bus_gnt,
    input  logic              snp_valid,
    input  bus_op_e           snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              bus_req,
    output logic              cmd_valid,
    output bus_op_e           cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              commit_en,
    output logic [TAG_W-1:0]  commit_tag,
    output line_st_e          commit_st
);

    typedef enum logic [2:0] {S_IDLE, S_LOOK, S_ARB, S_WB, S_MISS} fsm_e;

    fsm_e              state_q, state_d;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              tag_hit, hit, conflict, need_wb;
    logic [TAG_W-1:0]  req_tag;

    assign req_idx  = addr_q[IDX_W-1:0];
    assign req_tag  = addr_q[ADDR_W-1:IDX_W];
    assign tag_hit  = (line_tag == req_tag) && (line_st != ST_INV);
    assign hit      = tag_hit && (wr_q ? (line_st == ST_EXC) : 1'b1);
    assign need_wb  = (line_st == ST_EXC) && !tag_hit;
    assign conflict = snp_valid && (snp_addr == addr_q) &&
                      (snp_op == BOP_RDMISS || snp_op == BOP_WRMISS);

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: if (cpu_req) state_d = S_LOOK;
            S_LOOK: if (!conflict) state_d = hit ? S_IDLE : S_ARB;
            S_ARB: begin
                if (conflict)     state_d = S_LOOK;
                else if (bus_gnt) state_d = need_wb ? S_WB : S_MISS;
            end
            S_WB:   state_d = S_MISS;
            S_MISS: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_MISS) ||
                       (state_q == S_LOOK && !conflict && hit);
            if (state_q == S_IDLE && cpu_req) begin
                wr_q   <= cpu_wr;
                addr_q <= cpu_addr;
            end
        end
    end

    assign cpu_ready  = (state_q == S_IDLE);
    assign cpu_done   = done_q;
    assign bus_req    = (state_q == S_ARB) || (state_q == S_WB) || (state_q == S_MISS);
    assign cmd_valid  = (state_q == S_WB) || (state_q == S_MISS);
    assign cmd_op     = (state_q == S_WB)   ? BOP_WBACK :
                        (state_q == S_MISS) ? (wr_q ? BOP_WRMISS : BOP_RDMISS) :
                        BOP_NONE;
    assign cmd_addr   = (state_q == S_WB) ? {line_tag, req_idx} : addr_q;
    assign commit_en  = (state_q == S_MISS);
    assign commit_tag = req_tag;
    assign commit_st  = wr_q ? ST_EXC : ST_SHR;

    assert_cmd_granted_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> bus_gnt);

    assert_wback_then_miss_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == BOP_WBACK) |=> (cmd_valid && cmd_op != BOP_WBACK));

    assert_restart_drops_req_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ARB && conflict) |=> !bus_req);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

endmodule

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd_op,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush
);

    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    bus_op_e          snp_op_e, cmd_op_e;
    logic [IDX_W-1:0] idx_a, idx_b, commit_idx;
    logic [TAG_W-1:0] tag_a, tag_b, commit_tag;
    line_st_e         st_a, st_b, commit_st, snp_st;
    logic             commit_en, snp_en;

    assign snp_op_e   = bus_op_e'(snp_op);
    assign bus_cmd_op = cmd_op_e;
    assign commit_idx = idx_a;

    msi_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .bus_gnt    (bus_gnt),
        .rd_idx_a   (idx_a),
        .tag_a      (tag_a),
        .st_a       (st_a),
        .rd_idx_b   (idx_b),
        .tag_b      (tag_b),
        .st_b       (st_b),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .commit_tag (commit_tag),
        .commit_st  (commit_st),
        .snp_en     (snp_en),
        .snp_idx    (idx_b),
        .snp_st     (snp_st)
    );

    msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_op    (snp_op_e),
        .snp_addr  (snp_addr),
        .line_tag  (tag_b),
        .line_st   (st_b),
        .look_idx  (idx_b),
        .upd_en    (snp_en),
        .upd_st    (snp_st),
        .flush     (snp_flush)
    );

    msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .req_idx    (idx_a),
        .line_tag   (tag_a),
        .line_st    (st_a),
        .bus_gnt    (bus_gnt),
        .snp_valid  (snp_valid),
        .snp_op     (snp_op_e),
        .snp_addr   (snp_addr),
        .bus_req    (bus_req),
        .cmd_valid  (bus_cmd_valid),
        .cmd_op     (cmd_op_e),
        .cmd_addr   (bus_cmd_addr),
        .commit_en  (commit_en),
        .commit_tag (commit_tag),
        .commit_st  (commit_st)
    );

endmodule

// File: tb/test_snoop_msi_ctrl.sv
module test_snoop_msi_ctrl;

    localparam int OP_RD = 1, OP_WR = 2, OP_WB = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_ready, cpu_done, bus_req, bus_gnt, bus_cmd_valid, snp_flush;
    logic [1:0]  bus_cmd_op;
    logic [15:0] bus_cmd_addr;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_op = '0;
    logic [15:0] snp_addr = '0;
    logic        allow_gnt = 1'b1;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int          cyc;
        int          op;
        logic [15:0] addr;
        string       rq;
    } exp_t;

    exp_t bus_q[$];
    exp_t done_q[$];
    exp_t flush_q[$];

    assign bus_gnt = bus_req && allow_gnt;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    snoop_msi_ctrl i_snoop_msi_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd_op(bus_cmd_op), .bus_cmd_addr(bus_cmd_addr),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_flush(snp_flush)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic exp_t mk(input int c, input int op, input logic [15:0] a,
                                input string rq);
        exp_t e;
        e.cyc = c; e.op = op; e.addr = a; e.rq = rq;
        return e;
    endfunction

    // Monitor: scoreboard against the queued expectations.
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (bus_cmd_valid) begin
                if (bus_q.size() == 0) begin
                    chk(0, "R1", "unexpected bus command op", int'(bus_cmd_op), 0);
                end else begin
                    e = bus_q.pop_front();
                    chk(cyc == e.cyc, e.rq, "bus command cycle", cyc, e.cyc);
                    chk(int'(bus_cmd_op) == e.op, e.rq, "bus command op", int'(bus_cmd_op), e.op);
                    chk(bus_cmd_addr == e.addr, e.rq, "bus command addr",
                        int'(bus_cmd_addr), int'(e.addr));
                end
            end
            if (cpu_done) begin
                if (done_q.size() == 0) begin
                    chk(0, "R2", "unexpected cpu_done", 1, 0);
                end else begin
                    e = done_q.pop_front();
                    chk(cyc == e.cyc, e.rq, "cpu_done cycle", cyc, e.cyc);
                end
            end
            if (snp_flush) begin
                if (flush_q.size() == 0) begin
                    chk(0, "R7", "unexpected snp_flush", 1, 0);
                end else begin
                    e = flush_q.pop_front();
                    chk(cyc == e.cyc, e.rq, "snp_flush cycle", cyc, e.cyc);
                end
            end
        end
    end

    // kind 0: hit, 1: miss, 2: miss preceded by write-back of victim
    task automatic access(input bit wr, input logic [15:0] a, input int kind,
                          input logic [15:0] victim, input string rq);
        int c;
        int mop;
        @(posedge clk); #1;
        c = cyc;
        mop = wr ? OP_WR : OP_RD;
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
        if (kind == 0) begin
            done_q.push_back(mk(c + 2, 0, a, rq));
        end else if (kind == 1) begin
            bus_q.push_back(mk(c + 3, mop, a, rq));
            done_q.push_back(mk(c + 4, 0, a, rq));
        end else begin
            bus_q.push_back(mk(c + 3, OP_WB, victim, rq));
            bus_q.push_back(mk(c + 4, mop, a, rq));
            done_q.push_back(mk(c + 5, 0, a, rq));
        end
        @(posedge clk); #1;
        cpu_req = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    task automatic snoop(input int op, input logic [15:0] a, input bit fl,
                         input string rq);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_op = 2'(op); snp_addr = a;
        if (fl) flush_q.push_back(mk(cyc + 1, 0, a, rq));
        @(posedge clk); #1;
        snp_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(cpu_ready == 1'b1, "R10", "cpu_ready after reset", int'(cpu_ready), 1);
        chk(bus_req == 1'b0, "R10", "bus_req after reset", int'(bus_req), 0);
        chk(bus_cmd_valid == 1'b0, "R10", "bus_cmd_valid after reset", int'(bus_cmd_valid), 0);
        chk(cpu_done == 1'b0 && snp_flush == 1'b0, "R10", "done/flush after reset",
            int'(cpu_done) + int'(snp_flush), 0);

        access(0, 16'h0010, 1, '0, "R4");   // R4: read miss, Shared
        access(0, 16'h0010, 0, '0, "R8");   // R8: read hit on Shared
        access(1, 16'h0010, 1, '0, "R5");   // R5: write to Shared -> write miss
        access(1, 16'h0010, 0, '0, "R8");   // R8: write hit on Exclusive
        snoop(OP_WB, 16'h0010, 0, "R6");    // R6: snooped write-back ignored
        access(1, 16'h0010, 0, '0, "R6");   // still Exclusive
        snoop(OP_RD, 16'h0010, 1, "R7");    // R7: read miss on Exclusive -> flush, Shared
        access(0, 16'h0010, 0, '0, "R7");   // read hit on Shared
        access(1, 16'h0010, 1, '0, "R7");   // write needs bus, so it was Shared
        snoop(OP_WR, 16'h0010, 1, "R7");    // R7: write miss on Exclusive -> flush, Invalid
        access(0, 16'h0010, 1, '0, "R6");   // R6: invalidated -> read miss
        snoop(OP_WR, 16'h0110, 0, "R6");    // R6: tag mismatch, no effect
        access(0, 16'h0010, 0, '0, "R6");   // still Shared
        snoop(OP_WR, 16'h0010, 0, "R6");    // R6: invalidate Shared, no flush
        access(0, 16'h0010, 1, '0, "R6");
        access(1, 16'h0021, 1, '0, "R5");   // R5: write to Invalid -> Exclusive
        access(1, 16'h0031, 2, 16'h0021, "R9"); // R9: write-back of victim first
        access(0, 16'h0012, 1, '0, "R4");
        access(0, 16'h0022, 1, '0, "R4");   // Shared victim needs no write-back

        // R1/R3: conflicting snoop during arbitration, grant held back
        allow_gnt = 1'b0;
        @(posedge clk); #1;
        c = cyc;
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 16'h0010;   // line is Shared
        @(posedge clk); #1;
        cpu_req = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(bus_req == 1'b1, "R2", "bus_req during arbitration", int'(bus_req), 1);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_op = 2'(OP_WR); snp_addr = 16'h0010;
        @(posedge clk); #1;
        snp_valid = 1'b0;
        @(negedge clk);
        chk(bus_req == 1'b0, "R3", "bus_req after conflicting snoop", int'(bus_req), 1'b0);
        chk(cyc == c + 4, "R3", "restart cycle", cyc, c + 4);
        bus_q.push_back(mk(c + 6, OP_WR, 16'h0010, "R3"));
        done_q.push_back(mk(c + 7, 0, 16'h0010, "R3"));
        allow_gnt = 1'b1;
        repeat (6) @(posedge clk);
        access(1, 16'h0010, 0, '0, "R3");   // request completed as Exclusive

        // R1: no grant means no command and no state change
        allow_gnt = 1'b0;
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 16'h0044;
        @(posedge clk); #1;
        cpu_req = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(cpu_ready == 1'b0 && bus_req == 1'b1, "R1", "waiting for grant",
            int'(bus_req), 1);
        @(posedge clk); #1;
        c = cyc;
        allow_gnt = 1'b1;
        bus_q.push_back(mk(c + 1, OP_RD, 16'h0044, "R1"));
        done_q.push_back(mk(c + 2, 0, 16'h0044, "R1"));
        repeat (6) @(posedge clk);

        repeat (4) @(posedge clk);
        chk(bus_q.size() == 0, "R2", "bus expectations left", bus_q.size(), 0);
        chk(done_q.size() == 0, "R2", "done expectations left", done_q.size(), 0);
        chk(flush_q.size() == 0, "R7", "flush expectations left", flush_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule